// File: doc/BRIEF.md
# Two-Phase Step-Down Switching Mode Controller

This block is the digital timing and mode logic for a pair of synchronous step-down converters that share one input supply. A free-running period counter gives each converter a cycle-start pulse. Converter 0 is the master. Converter 1 starts half a period later, so the two input current pulses interleave. Within each cycle the block turns the high-side switch on and keeps it on until the ramp comparator or the current-limit comparator trips. It then holds both switches off for a fixed gap and lets the low-side switch conduct until the next cycle start.

Each converter leaves fixed-frequency operation on its own. It does so when the light-load indication has been present at enough consecutive cycle starts. In power-save mode it switches only while the output sits below the upper (+1%) window comparator, and it idles once the output is back above that comparator. When the output drops below the lower (-1%) comparator, the converter returns to fixed-frequency operation. A per-converter force bit pins a converter to fixed frequency. The converter enable is the exclusive-or of a pin and a register bit. A thermal fault on either side stops both converters. All comparators and the light-load detect are digital inputs sampled on the system clock.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, before any cycle start, every hs_on_o, ls_on_o and pfm_o bit is 0.
- R2: At a cycle start, an enabled converter in fixed-frequency mode turns hs_on_o on in the next cycle. A ramp_trip_i pulse during the high-side phase turns hs_on_o off at the next edge.
- R3: ilim_i ends the high-side phase exactly like ramp_trip_i.
- R4: After the high-side phase ends, hs_on_o and ls_on_o are both 0 for DEAD_CLKS clock cycles. ls_on_o is then 1 until the next cycle start, which turns ls_on_o off and hs_on_o on at the same edge. The two outputs of one converter are never 1 together.
- R5: Converter 0 starts when the period counter is at 0, and converter 1 starts when the counter is at PERIOD_CLKS/2 (4 by default).
- R6: When no trip arrives before the next cycle start, hs_on_o stays 1 across that start (100% duty), and ls_on_o stays 0.
- R7: A converter enters power-save (pfm_o=1) at the LIGHT_CYCLES-th consecutive cycle start sampled with light_load_i=1. A start with light_load_i=0 restarts the count.
- R8: In power-save, a cycle start with above_hi_i=1 (output above the +1% comparator) leaves both switches off. While idle, above_hi_i=0 starts a high-side pulse at the next edge, with no need to wait for a cycle start.
- R9: In power-save, below_lo_i=1 (output below the -1% comparator) clears pfm_o at the next edge.
- R10: fpwm_i=1 clears pfm_o at the next edge and keeps it 0, and the converter then switches at every cycle start whatever above_hi_i is. With fpwm_i=0 (the default), automatic entry into power-save works.
- R11: A converter runs only when en_pin_i XOR en_bit_i is 1. Otherwise both of its gate outputs are 0 from the next edge.
- R12: A 1 on either therm_fault_i bit turns off all gate outputs of both converters at the next edge. Once the fault clears, each converter restarts at its own next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_trip_i | input | NCONV | Per converter: PWM ramp comparator tripped |
| ilim_i | input | NCONV | Per converter: high-side current limit reached |
| above_hi_i | input | NCONV | Per converter: output above the +1% threshold |
| below_lo_i | input | NCONV | Per converter: output below the -1% threshold |
| light_load_i | input | NCONV | Per converter: average current below the power-save threshold |
| en_pin_i | input | NCONV | Per converter: enable pin level |
| en_bit_i | input | NCONV | Per converter: enable register bit |
| fpwm_i | input | NCONV | Per converter: force fixed-frequency operation |
| therm_fault_i | input | NCONV | Per converter: over-temperature flag |
| hs_on_o | output | NCONV | Per converter: high-side switch gate enable |
| ls_on_o | output | NCONV | Per converter: low-side switch gate enable |
| pfm_o | output | NCONV | Per converter: 1 while in power-save mode |

## Verification
The bench tracks the period counter on its own and checks the gap length cycle by cycle. A design that counted the gap off by one, or let the low side on during it, fails there. It checks the interrupted light-load count, so a counter that only saturates and never restarts enters power-save too early. It checks that the half-period offset puts converter 1 at count 4 and not at the master's start. It then covers immediate restart from power-save idle, exit on the lower comparator, a held high side across a cycle start, and the XOR enable with both inputs high, where an OR would wrongly keep the converter running.

// File: rtl/buck_pkg.sv
package buck_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_HS,
    ST_GAP,
    ST_LS,
    ST_IDLE
  } sw_state_e;
endpackage

// File: rtl/buck_phase_timer.sv
module buck_phase_timer #(
  parameter int PERIOD_CLKS = 8,
  parameter int NCONV       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [NCONV-1:0] start_o
);
  localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD_CLKS - 1))   cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // evenly spaced phase offsets, converter 0 is the master
  for (genvar i = 0; i < NCONV; i++) begin : g_phase
    assign start_o[i] = (cnt_q == CW'((i * PERIOD_CLKS) / NCONV));
  end

  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o)); // R5
endmodule

// File: rtl/buck_mode_sel.sv
module buck_mode_sel #(
  parameter int LIGHT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic light_i,
  input  logic below_lo_i,
  input  logic fpwm_i,
  output logic pfm_o
);
  localparam int LW = $clog2(LIGHT_CYCLES + 1);

  logic [LW-1:0] light_cnt_q;
  logic          pfm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfm_q       <= 1'b0;
      light_cnt_q <= '0;
    end else if (!run_i || fpwm_i) begin
      pfm_q       <= 1'b0;
      light_cnt_q <= '0;
    end else if (pfm_q) begin
      light_cnt_q <= '0;
      if (below_lo_i) pfm_q <= 1'b0;
    end else if (start_i) begin
      if (!light_i) begin
        light_cnt_q <= '0;
      end else if (light_cnt_q == LW'(LIGHT_CYCLES - 1)) begin
        pfm_q       <= 1'b1;
        light_cnt_q <= '0;
      end else begin
        light_cnt_q <= light_cnt_q + 1'b1;
      end
    end
  end

  assign pfm_o = pfm_q;

  AST_FPWM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpwm_i |=> !pfm_o); // R10
  AST_EXIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfm_o && below_lo_i) |=> !pfm_o); // R9
  AST_ENTRY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pfm_o) |-> $past(start_i && light_i && run_i)); // R7
endmodule

// File: rtl/buck_switch_seq.sv
module buck_switch_seq
  import buck_pkg::*;
#(
  parameter int DEAD_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic pfm_i,
  input  logic above_hi_i,
  input  logic trip_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DW = $clog2(DEAD_CLKS + 1);

  sw_state_e     st_q;
  logic [DW-1:0] gap_q;
  sw_state_e     launch;

  // at a cycle start, power-save with output high means stay idle
  assign launch = (pfm_i && above_hi_i) ? ST_IDLE : ST_HS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      gap_q <= '0;
    end else if (!run_i) begin
      st_q  <= ST_OFF;
      gap_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF:  if (start_i) st_q <= ST_HS;
        ST_HS: begin
          // a start while still on keeps the switch on (full duty)
          if (!start_i && trip_i) begin
            st_q  <= ST_GAP;
            gap_q <= '0;
          end
        end
        ST_GAP: begin
          if (start_i)                          st_q  <= launch;
          else if (gap_q == DW'(DEAD_CLKS - 1)) st_q  <= ST_LS;
          else                                  gap_q <= gap_q + 1'b1;
        end
        ST_LS:   if (start_i) st_q <= launch;
        ST_IDLE: if (pfm_i ? !above_hi_i : start_i) st_q <= ST_HS;
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign hs_o = (st_q == ST_HS);
  assign ls_o = (st_q == ST_LS);

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o)); // R4
  AST_LS_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> $past(!hs_o)); // R4
  AST_HS_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_o) && !$past(pfm_i)) |-> $past(start_i)); // R2
  AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_o && start_i && run_i) |=> hs_o); // R6
  AST_OFF_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!hs_o && !ls_o)); // R11
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl #(
  parameter int NCONV        = 2,
  parameter int PERIOD_CLKS  = 8,
  parameter int DEAD_CLKS    = 2,
  parameter int LIGHT_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCONV-1:0] ramp_trip_i,
  input  logic [NCONV-1:0] ilim_i,
  input  logic [NCONV-1:0] above_hi_i,
  input  logic [NCONV-1:0] below_lo_i,
  input  logic [NCONV-1:0] light_load_i,
  input  logic [NCONV-1:0] en_pin_i,
  input  logic [NCONV-1:0] en_bit_i,
  input  logic [NCONV-1:0] fpwm_i,
  input  logic [NCONV-1:0] therm_fault_i,
  output logic [NCONV-1:0] hs_on_o,
  output logic [NCONV-1:0] ls_on_o,
  output logic [NCONV-1:0] pfm_o
);
  logic [NCONV-1:0] start;
  logic [NCONV-1:0] run;
  logic             fault_any;

  assign fault_any = |therm_fault_i;

  buck_phase_timer #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .NCONV      (NCONV)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_o(start)
  );

  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    assign run[i] = (en_pin_i[i] ^ en_bit_i[i]) && !fault_any;

    buck_mode_sel #(
      .LIGHT_CYCLES(LIGHT_CYCLES)
    ) u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[i]),
      .start_i   (start[i]),
      .light_i   (light_load_i[i]),
      .below_lo_i(below_lo_i[i]),
      .fpwm_i    (fpwm_i[i]),
      .pfm_o     (pfm_o[i])
    );

    buck_switch_seq #(
      .DEAD_CLKS(DEAD_CLKS)
    ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[i]),
      .start_i   (start[i]),
      .pfm_i     (pfm_o[i]),
      .above_hi_i(above_hi_i[i]),
      .trip_i    (ramp_trip_i[i] | ilim_i[i]),
      .hs_o      (hs_on_o[i]),
      .ls_o      (ls_on_o[i])
    );
  end

  AST_THERMAL_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |=> (hs_on_o == '0 && ls_on_o == '0)); // R12
endmodule

// File: tb/buck_mode_ctrl_test.sv
module buck_mode_ctrl_test;
  localparam int PER = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ramp = '0, ilim = '0, above = '0, below = '0, light = '0;
  logic [1:0] en_pin = '0, en_bit = '0, fpwm = '0, fault = '0;
  logic [1:0] hs, ls, pfm;

  int unsigned nedge = 0;
  int total = 0;
  int fails = 0;
  logic seen;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) nedge <= nedge + 1;

  buck_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ramp_trip_i(ramp), .ilim_i(ilim),
    .above_hi_i(above), .below_lo_i(below), .light_load_i(light),
    .en_pin_i(en_pin), .en_bit_i(en_bit), .fpwm_i(fpwm), .therm_fault_i(fault),
    .hs_on_o(hs), .ls_on_o(ls), .pfm_o(pfm)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // park at the negedge just before the edge where the period count is k
  task automatic wait_cnt(input int k);
    while ((nedge % PER) != k) @(negedge clk);
  endtask

  task automatic pass_start0(input int n);
    for (int i = 0; i < n; i++) begin
      wait_cnt(0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hs in reset", hs, 2'b00);
    chk("R1 ls in reset", ls, 2'b00);
    chk("R1 pfm in reset", pfm, 2'b00);
    rst_n = 1'b1;
    chk("R1 hs after release", hs, 2'b00);

    // R2 / R4: basic cycle on converter 0
    en_pin[0] = 1'b1;
    wait_cnt(0); @(negedge clk);
    chk("R2 hs on at start", hs, 2'b01);
    chk("R5 conv1 idle at master start", hs & 2'b10, 2'b00);
    ramp[0] = 1'b1;
    @(negedge clk);
    chk("R2 hs off after trip", hs, 2'b00);
    chk("R4 gap cycle 1", ls, 2'b00);
    ramp[0] = 1'b0;
    @(negedge clk);
    chk("R4 gap cycle 2", {hs[0], ls[0]}, 2'b00);
    @(negedge clk);
    chk("R4 ls after gap", {hs[0], ls[0]}, 2'b01);
    wait_cnt(0);
    chk("R4 ls held to start", {hs[0], ls[0]}, 2'b01);
    @(negedge clk);
    chk("R4 hs at next start", {hs[0], ls[0]}, 2'b10);

    // R3: current limit ends the on phase
    ilim[0] = 1'b1;
    @(negedge clk);
    chk("R3 ilim ends hs", hs, 2'b00);
    ilim[0] = 1'b0;

    // R6: no trip across a start
    pass_start0(1);
    chk("R6 hs at start", hs, 2'b01);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ls[0] || !hs[0]) seen = 1'b1;
    end
    chk("R6 full duty held", {seen, hs[0]}, 2'b01);

    // R5: converter 1 half a period later
    ramp = 2'b11;
    en_pin[1] = 1'b1;
    wait_cnt(0); @(negedge clk);
    chk("R5 conv1 not at count 0", hs & 2'b10, 2'b00);
    wait_cnt(4);
    chk("R5 conv1 before count 4", hs & 2'b10, 2'b00);
    @(negedge clk);
    chk("R5 conv1 on at count 4", hs & 2'b10, 2'b10);

    // R12: shared thermal shutdown
    fault[1] = 1'b1;
    @(negedge clk);
    chk("R12 all hs off", hs, 2'b00);
    chk("R12 all ls off", ls, 2'b00);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hs != 2'b00 || ls != 2'b00) seen = 1'b1;
    end
    chk("R12 stays off", {1'b0, seen}, 2'b00);
    fault[1] = 1'b0;
    wait_cnt(0); @(negedge clk);
    chk("R12 conv0 resumes", hs & 2'b01, 2'b01);
    wait_cnt(4); @(negedge clk);
    chk("R12 conv1 resumes", hs & 2'b10, 2'b10);

    // R11: xor enable
    en_bit[1] = 1'b1;
    @(negedge clk);
    chk("R11 pin=bit=1 off", {hs[1], ls[1]}, 2'b00);
    wait_cnt(4); @(negedge clk);
    chk("R11 pin=bit=1 no start", {hs[1], ls[1]}, 2'b00);
    en_pin[1] = 1'b0;
    wait_cnt(4); @(negedge clk);
    chk("R11 bit only runs", {hs[1], ls[1]}, 2'b10);
    en_bit[1] = 1'b0;
    @(negedge clk);
    chk("R11 both 0 off", {hs[1], ls[1]}, 2'b00);

    // R7: light-load entry with interrupted count
    light[0] = 1'b1;
    pass_start0(7);
    chk("R7 no entry after 7", pfm, 2'b00);
    light[0] = 1'b0;
    pass_start0(1);
    light[0] = 1'b1;
    pass_start0(7);
    chk("R7 count restarted", pfm, 2'b00);
    above[0] = 1'b1;
    pass_start0(1);
    chk("R7 entry on 8th start", pfm, 2'b01);

    // R8: hysteretic operation
    pass_start0(1);
    chk("R8 idle above window", {hs[0], ls[0]}, 2'b00);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hs[0] || ls[0]) seen = 1'b1;
    end
    chk("R8 no switching while high", {1'b0, seen}, 2'b00);
    wait_cnt(3);
    above[0] = 1'b0;
    @(negedge clk);
    chk("R8 immediate pulse", {hs[0], pfm[0]}, 2'b11);
    above[0] = 1'b1;
    @(negedge clk);
    chk("R8 pulse ends on trip", hs, 2'b00);
    pass_start0(1);
    chk("R8 stop at start when high", {hs[0], ls[0], pfm[0]}, 3'b001);

    // R9: exit on lower comparator
    light[0] = 1'b0;
    wait_cnt(2);
    below[0] = 1'b1;
    above[0] = 1'b0;
    @(negedge clk);
    chk("R9 pfm cleared", pfm, 2'b00);
    below[0] = 1'b0;
    pass_start0(1);
    chk("R9 fixed cycle resumes", hs, 2'b01);

    // R10: forced fixed frequency
    fpwm[0] = 1'b1;
    light[0] = 1'b1;
    above[0] = 1'b1;
    pass_start0(10);
    chk("R10 no entry when forced", pfm, 2'b00);
    chk("R10 switches though high", hs, 2'b01);
    fpwm[0] = 1'b0;
    pass_start0(8);
    chk("R10 auto entry by default", pfm, 2'b01);
    fpwm[0] = 1'b1;
    @(negedge clk);
    chk("R10 force clears pfm", pfm, 2'b00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule